// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block sits on the host side of an 8-bit converter that has a parallel output bus. When it gets a request it drives an active-low start pulse to the converter. It then waits for the converter's completion line to fall, which it treats as an interrupt. When that happens it lowers chip-select and read together for a fixed number of clock cycles, latches the data bus on the last of those cycles, and returns the byte with a one-cycle valid strobe.

The completion line idles high and is sampled through a two-flop synchroniser. Only a falling edge of the synchronised copy counts as completion, and only while the sequencer is waiting for it. A converter that holds the line low after power-up therefore never produces a false result. Edges that occur during the start pulse are also ignored. If no edge arrives within the timeout window, the sequencer raises a one-cycle error strobe and returns to idle. From reset onward the start line is driven high and never left floating.

The state machine has four states. IDLE accepts a request and moves to START. START holds the start line low and moves to WAIT when its count expires. WAIT moves to READ on a completion edge, or back to IDLE on timeout. READ holds the strobes low and moves to IDLE when its count expires, at which point it captures the data.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `conv_n_o`, `cs_n_o` and `rd_n_o` are high, and `busy_o`, `valid_o` and `timeout_o` are low.
- R2: A request seen in IDLE drives `conv_n_o` low for exactly `START_LO_CYC` cycles, starting in the cycle after the request.
- R3: A request that arrives while `busy_o` is high is dropped. No second start pulse follows the current transaction.
- R4: In WAIT, a falling edge on `eoc_n_i` lowers `cs_n_o` and `rd_n_o` at the third rising clock edge after the input falls. Both stay low for exactly `RD_CYC` cycles.
- R5: `data_o` carries the bus value that was present during the last READ cycle. `valid_o` is high for exactly one cycle, namely the cycle right after READ ends.
- R6: A low level on `eoc_n_i` at power-up, and a falling edge on it before WAIT is entered, never start a read. No strobe falls and no valid is given.
- R7: If WAIT lasts `TO_CYC` cycles with no edge, `timeout_o` pulses for one cycle and the block returns to IDLE, so the transaction is busy for `START_LO_CYC + TO_CYC` cycles. An edge seen on the final WAIT cycle wins over the timeout.
- R8: `cs_n_o` and `rd_n_o` always move together, and they are never low while `conv_n_o` is low.
- R9: `busy_o` is high in every state except IDLE. A successful transaction stays busy for `START_LO_CYC` + (WAIT cycles) + `RD_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, taken only in IDLE |
| eoc_n_i | input | 1 | Converter completion line, idle high, asynchronous |
| bus_i | input | DATA_W | Converter parallel data bus |
| conv_n_o | output | 1 | Active-low conversion start, high from reset |
| cs_n_o | output | 1 | Active-low chip-select |
| rd_n_o | output | 1 | Active-low read strobe |
| busy_o | output | 1 | High while a transaction is in progress |
| data_o | output | DATA_W | Captured result |
| valid_o | output | 1 | One-cycle strobe marking `data_o` |
| timeout_o | output | 1 | One-cycle strobe on a missing completion edge |

## Verification
The hardest case to reach from the ports is a completion edge that lands on the very cycle the timeout would fire, together with its neighbours on either side. The synchroniser delay means the input must be lowered a precise number of cycles before the WAIT count ends. The stimulus therefore sweeps the delay between the end of the start pulse and the falling edge over every value from zero to past the timeout window. For each delay, the bench predicts arithmetically whether a read or a timeout should occur. Separate runs hold the line low from power-up and drop it during the start pulse, to show that neither a level nor an early edge is taken as completion.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READ  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/adc_eoc_edge.sv
// Two-flop synchroniser plus one history flop on the completion line.
// Flops reset low, so a line that is already low at power-up never
// produces a falling edge.
module adc_eoc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_n_i,
    output logic fall_o
);

    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], eoc_n_i};
    end

    // high for one cycle when the synchronised copy goes from 1 to 0
    assign fall_o = sh_q[2] & ~sh_q[1];

endmodule

// File: rtl/adc_cyc_timer.sv
// Shared state-duration counter. Restarts from zero on every state change.
module adc_cyc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [CW-1:0] lim_i,
    output logic          last_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == lim_i - 1'b1);

    // the count never runs past the limit of the state it is timing
    p_cnt_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |-> (cnt_q < lim_i));

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int START_LO_CYC = 3,
    parameter int RD_CYC       = 4,
    parameter int TO_CYC       = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              eoc_n_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              conv_n_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              timeout_o
);

    localparam int MAX_A = (START_LO_CYC > RD_CYC) ? START_LO_CYC : RD_CYC;
    localparam int MAX_L = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
    localparam int CW    = $clog2(MAX_L + 1);

    rd_state_e st_q, st_d;
    logic      eoc_fall;
    logic      cnt_last;
    logic      restart;
    logic [CW-1:0] lim;

    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              to_q;

    adc_eoc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoc_n_i (eoc_n_i),
        .fall_o  (eoc_fall)
    );

    adc_cyc_timer #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .lim_i     (lim),
        .last_o    (cnt_last)
    );

    // duration of the current state
    always_comb begin
        lim = CW'(RD_CYC);
        unique case (st_q)
            ST_START: lim = CW'(START_LO_CYC);
            ST_WAIT:  lim = CW'(TO_CYC);
            ST_READ:  lim = CW'(RD_CYC);
            ST_IDLE:  lim = CW'(RD_CYC);
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_i)    st_d = ST_START;
            ST_START: if (cnt_last) st_d = ST_WAIT;
            ST_WAIT: begin
                if (eoc_fall)       st_d = ST_READ;
                else if (cnt_last)  st_d = ST_IDLE;
            end
            ST_READ:  if (cnt_last) st_d = ST_IDLE;
        endcase
    end

    assign restart = (st_d != st_q) || (st_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // registered result and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            valid_q <= (st_q == ST_READ) && cnt_last;
            to_q    <= (st_q == ST_WAIT) && !eoc_fall && cnt_last;
            if ((st_q == ST_READ) && cnt_last) data_q <= bus_i;
        end
    end

    // pin outputs decoded from the state
    always_comb begin
        conv_n_o = (st_q != ST_START);
        cs_n_o   = (st_q != ST_READ);
        rd_n_o   = (st_q != ST_READ);
        busy_o   = (st_q != ST_IDLE);
    end

    assign data_o    = data_q;
    assign valid_o   = valid_q;
    assign timeout_o = to_q;

    p_start_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_o) |-> $past(req_i));

    p_busy_drops_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && conv_n_o) |=> !$fell(conv_n_o));

    p_read_follows_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(eoc_fall));

    p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_read_only_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(busy_o && conv_n_o));

    p_timeout_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    p_no_valid_with_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && timeout_o));

    p_no_read_in_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!conv_n_o && !rd_n_o));

endmodule

// File: tb/sim_adc_rd_ctrl.sv
module sim_adc_rd_ctrl;

    localparam int SL = 2;
    localparam int RD = 3;
    localparam int TO = 12;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       req   = 1'b0;
    logic       eoc_n = 1'b0;
    logic [7:0] bus   = 8'h00;
    logic       conv_n, cs_n, rd_n, busy, valid, tmo;
    logic [7:0] data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_rd_ctrl #(.DATA_W(8), .START_LO_CYC(SL), .RD_CYC(RD), .TO_CYC(TO)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .eoc_n_i   (eoc_n),
        .bus_i     (bus),
        .conv_n_o  (conv_n),
        .cs_n_o    (cs_n),
        .rd_n_o    (rd_n),
        .busy_o    (busy),
        .data_o    (data),
        .valid_o   (valid),
        .timeout_o (tmo)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic chk_idle_pins(input string rq);
        chk(conv_n == 1'b1 && cs_n == 1'b1 && rd_n == 1'b1, rq,
            {29'd0, conv_n, cs_n, rd_n}, 7);
        chk(busy == 1'b0 && valid == 1'b0 && tmo == 1'b0, rq,
            {29'd0, busy, valid, tmo}, 0);
    endtask

    // One transaction. d: cycles from the end of the start pulse to the
    // falling edge. early: drop the line together with the request.
    task automatic run_conv(input int d, input bit early, input bit extra,
                            input logic [7:0] base, input bit exp_ok);
        int t = 0;
        int conv_lo = 0;
        int rise_t = -1;
        int drop_t = -1;
        int cs_lo = 0;
        int cs_first = -1;
        int busy_n = 0;
        int vcnt = 0;
        int tcnt = 0;
        int tail = -1;
        int pair_bad = 0;
        logic [7:0] got = 8'h00;
        logic [7:0] exp_data;
        @(negedge clk);
        req = 1'b1;
        if (early) begin
            eoc_n = 1'b0;
            drop_t = 0;
        end
        while (t < 300) begin
            @(negedge clk);
            t++;
            if (!conv_n) conv_lo++;
            else if (conv_lo > 0 && rise_t < 0) rise_t = t;
            if (busy) busy_n++;
            if (cs_n != rd_n) pair_bad++;
            if (!cs_n && !conv_n) pair_bad++;
            if (!cs_n) begin
                if (cs_first < 0) cs_first = t;
                bus = base + 8'(cs_lo);
                cs_lo++;
            end
            if (valid) begin
                vcnt++;
                got = data;
            end
            if (tmo) tcnt++;
            if (t == 1) req = 1'b0;
            if (!early && rise_t > 0 && t == rise_t + d && drop_t < 0) begin
                eoc_n = 1'b0;
                drop_t = t;
            end
            if (extra && rise_t > 0 && t == rise_t + 1) req = 1'b1;
            if (extra && rise_t > 0 && t == rise_t + 2) req = 1'b0;
            if (busy_n > 0 && !busy && tail < 0) tail = t;
            if (tail > 0 && t >= tail + 2) break;
        end
        exp_data = base + 8'(RD - 1);
        chk(conv_lo == SL, "R2 start width", conv_lo, SL);
        chk(pair_bad == 0, "R8 strobe pairing", pair_bad, 0);
        if (exp_ok) begin
            chk(cs_first - drop_t == 3, "R4 edge to strobe", cs_first - drop_t, 3);
            chk(cs_lo == RD, "R4 strobe width", cs_lo, RD);
            chk(vcnt == 1, "R5 valid pulses", vcnt, 1);
            chk(got == exp_data, "R5 data", int'(got), int'(exp_data));
            chk(tcnt == 0, "R7 no timeout", tcnt, 0);
            chk(busy_n == SL + d + 3 + RD, "R9 busy span", busy_n, SL + d + 3 + RD);
        end else begin
            chk(tcnt == 1, "R7 timeout pulse", tcnt, 1);
            chk(vcnt == 0, "R6 no valid", vcnt, 0);
            chk(cs_lo == 0, "R6 no read", cs_lo, 0);
            chk(busy_n == SL + TO, "R7 busy span", busy_n, SL + TO);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lows;
        repeat (3) begin
            @(negedge clk);
            chk_idle_pins("R1 in reset");
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle_pins("R1 after reset");

        // R6: the line is still low from power-up, so no edge ever arrives
        run_conv(0, 1'b0, 1'b0, 8'h11, 1'b0);
        eoc_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4 R5 R7: sweep the edge position across the timeout boundary
        for (int d = 0; d <= TO; d++) begin
            run_conv(d, 1'b0, 1'b0, 8'(8'h30 + d * 7), d <= TO - 3);
            eoc_n = 1'b1;
            repeat (5) @(negedge clk);
        end

        // R6: an edge during the start pulse is stale
        run_conv(4, 1'b1, 1'b0, 8'h5A, 1'b0);
        eoc_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: a request raised in WAIT is dropped
        run_conv(2, 1'b0, 1'b1, 8'hC4, 1'b1);
        eoc_n = 1'b1;
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!conv_n || busy) lows++;
        end
        chk(lows == 0, "R3 dropped request", lows, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule